// File: doc/BRIEF.md
# Dual-Port Handshake Mailbox

This block passes single 32-bit words between a debug host and a device CPU that share one clock. There are two one-word mailboxes, one per direction. The outbound mailbox carries words from the host to the device and the inbound mailbox carries words from the device to the host. Each mailbox has a status flag that shows whether a word is waiting (FULL) or not (EMPTY). Each direction also carries a 7-bit software flag field that only the sending side may write.

Each side has its own port with a write strobe, a read strobe, an address and data. Read data is combinational and reflects the registered state during the cycle of the read. Any side effect of an access takes place at the next clock edge. A destructive read of a data word clears the mailbox flag. A peek address returns the same word and leaves every flag unchanged. The device may flush its own inbound word by reading it. The block raises a one-cycle event when the device consumes a waiting outbound word, and another when the device posts an inbound word.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset every data word, flag field and status bit reads as zero, and both event outputs are low.
- R2: A host write to offset 0x100 stores the word and sets the outbound status (bit 0 of offset 0x104) to 1. A further write while the status is 1 replaces the word and leaves the status at 1.
- R3: A device read of offset 0x100 returns the stored outbound word and clears the outbound status. A device read while the status is 0 returns the stored word and changes nothing. A host read of offset 0x100 never changes the status.
- R4: When the host writes offset 0x100 in the same cycle that the device reads it, the device receives the old word. After the edge the new word is stored and the status is 1.
- R5: A device write to offset 0x108 stores the word and sets the inbound status (bit 0 of offset 0x10C). A host read of 0x108, or a device read of 0x108 used as a flush, clears the status.
- R6: When the device writes offset 0x108 in the same cycle that the host reads it, the host receives the old word. After the edge the status is 1 and the new word is stored.
- R7: Offsets 0x110 (outbound word) and 0x114 (inbound word) return the current words from either port and change neither status flag.
- R8: A control word holds the status in bit 0, the flags in bits 7:1 and zeros above. Only the host writes the outbound flags, through bits 7:1 of a write to 0x104. Only the device writes the inbound flags, through bits 7:1 of a write to 0x10C. Device writes to 0x104 or 0x100 and host writes to 0x10C or 0x108 have no effect.
- R9: `txEvent` is high for exactly the one cycle after a device read of 0x100 that finds the outbound status at 1 with no host write to 0x100 in that cycle.
- R10: `rxEvent` is high for the one cycle after each device write to 0x108.
- R11: Read data is zero on a port whose read strobe is low, and zero for an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | 12 | Host byte offset |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data (combinational) |
| devWrEn | input | 1 | Device write strobe |
| devRdEn | input | 1 | Device read strobe |
| devAddr | input | 12 | Device byte offset |
| devWrData | input | 32 | Device write data |
| devRdData | output | 32 | Device read data (combinational) |
| txEvent | output | 1 | Pulse: device consumed a waiting outbound word |
| rxEvent | output | 1 | Pulse: device posted an inbound word |

## Verification
The handshake is exercised with clean fill-then-drain sequences, with overwrites while full and reads while empty, with writes and reads that collide in the same cycle on each mailbox, and with peeks between a fill and a drain. A clean sequence separates the destructive read from the peek path. A collision shows whether the old word reaches the reader and whether the status ends set. The misuse cases show that the status does not move and that no event is raised. Cross-side writes to the flag and data offsets are followed by reads that would expose any leak into the other side's state.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned OFF_TX_DATA = 'h100;
  localparam int unsigned OFF_TX_CTRL = 'h104;
  localparam int unsigned OFF_RX_DATA = 'h108;
  localparam int unsigned OFF_RX_CTRL = 'h10C;
  localparam int unsigned OFF_TX_PEEK = 'h110;
  localparam int unsigned OFF_RX_PEEK = 'h114;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_HOST = 0;
  localparam int unsigned PORT_DEV  = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TX_DATA,
    SEL_TX_CTRL,
    SEL_RX_DATA,
    SEL_RX_CTRL,
    SEL_TX_PEEK,
    SEL_RX_PEEK
  } mbx_sel_t;

  typedef struct packed {
    logic txLoad;
    logic txTake;
    logic txFlagLoad;
    logic rxLoad;
    logic rxTake;
    logic rxFlagLoad;
  } mbx_strobe_t;

endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              devWrEn,
  input  logic              devRdEn,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              txFull,
  output mbx_strobe_t       strobe,
  output mbx_sel_t          hostSel,
  output mbx_sel_t          devSel,
  output logic              txEvent,
  output logic              rxEvent
);

  localparam logic [ADDR_W-1:0] A_TX_DATA = ADDR_W'(OFF_TX_DATA);
  localparam logic [ADDR_W-1:0] A_TX_CTRL = ADDR_W'(OFF_TX_CTRL);
  localparam logic [ADDR_W-1:0] A_RX_DATA = ADDR_W'(OFF_RX_DATA);
  localparam logic [ADDR_W-1:0] A_RX_CTRL = ADDR_W'(OFF_RX_CTRL);
  localparam logic [ADDR_W-1:0] A_TX_PEEK = ADDR_W'(OFF_TX_PEEK);
  localparam logic [ADDR_W-1:0] A_RX_PEEK = ADDR_W'(OFF_RX_PEEK);

  function automatic mbx_sel_t decodeSel(input logic en, input logic [ADDR_W-1:0] addr);
    mbx_sel_t sel;
    sel = SEL_NONE;
    if (en) begin
      unique case (addr)
        A_TX_DATA: sel = SEL_TX_DATA;
        A_TX_CTRL: sel = SEL_TX_CTRL;
        A_RX_DATA: sel = SEL_RX_DATA;
        A_RX_CTRL: sel = SEL_RX_CTRL;
        A_TX_PEEK: sel = SEL_TX_PEEK;
        A_RX_PEEK: sel = SEL_RX_PEEK;
        default:   sel = SEL_NONE;
      endcase
    end
    return sel;
  endfunction

  logic hostTxWr;
  logic hostTxFlagWr;
  logic hostRxRd;
  logic devTxRd;
  logic devRxWr;
  logic devRxFlagWr;
  logic devRxRd;

  always_comb begin
    hostTxWr     = hostWrEn && (hostAddr == A_TX_DATA);
    hostTxFlagWr = hostWrEn && (hostAddr == A_TX_CTRL);
    hostRxRd     = hostRdEn && (hostAddr == A_RX_DATA);
    devTxRd      = devRdEn  && (devAddr  == A_TX_DATA);
    devRxWr      = devWrEn  && (devAddr  == A_RX_DATA);
    devRxFlagWr  = devWrEn  && (devAddr  == A_RX_CTRL);
    devRxRd      = devRdEn  && (devAddr  == A_RX_DATA);
  end

  always_comb begin
    strobe.txLoad     = hostTxWr;
    strobe.txTake     = devTxRd;
    strobe.txFlagLoad = hostTxFlagWr;
    strobe.rxLoad     = devRxWr;
    strobe.rxTake     = hostRxRd || devRxRd;
    strobe.rxFlagLoad = devRxFlagWr;
  end

  always_comb begin
    hostSel = decodeSel(hostRdEn, hostAddr);
    devSel  = decodeSel(devRdEn, devAddr);
  end

  // consumption event: a real hand-over, not a read of a stale word or a collision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEvent <= 1'b0;
      rxEvent <= 1'b0;
    end else begin
      txEvent <= devTxRd && txFull && !hostTxWr;
      rxEvent <= devRxWr;
    end
  end

endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FLAG_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbx_strobe_t       strobe,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] devWrData,
  input  mbx_sel_t          portSel [NUM_PORTS],
  output logic [DATA_W-1:0] portRd  [NUM_PORTS],
  output logic              txFull,
  output logic              rxFull
);

  localparam int unsigned PAD_W = DATA_W - FLAG_W - 1;

  logic [DATA_W-1:0] txWord;
  logic [DATA_W-1:0] rxWord;
  logic [FLAG_W-1:0] txFlags;
  logic [FLAG_W-1:0] rxFlags;
  logic [DATA_W-1:0] txCtrlWord;
  logic [DATA_W-1:0] rxCtrlWord;

  // outbound mailbox: load wins over take, so a collision ends FULL
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWord  <= '0;
      txFull  <= 1'b0;
      txFlags <= '0;
    end else begin
      if (strobe.txLoad) begin
        txWord <= hostWrData;
        txFull <= 1'b1;
      end else if (strobe.txTake) begin
        txFull <= 1'b0;
      end
      if (strobe.txFlagLoad) txFlags <= hostWrData[FLAG_W:1];
    end
  end

  // inbound mailbox: same priority rule
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxWord  <= '0;
      rxFull  <= 1'b0;
      rxFlags <= '0;
    end else begin
      if (strobe.rxLoad) begin
        rxWord <= devWrData;
        rxFull <= 1'b1;
      end else if (strobe.rxTake) begin
        rxFull <= 1'b0;
      end
      if (strobe.rxFlagLoad) rxFlags <= devWrData[FLAG_W:1];
    end
  end

  always_comb begin
    txCtrlWord = {{PAD_W{1'b0}}, txFlags, txFull};
    rxCtrlWord = {{PAD_W{1'b0}}, rxFlags, rxFull};
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rdPort
    always_comb begin
      unique case (portSel[p])
        SEL_TX_DATA, SEL_TX_PEEK: portRd[p] = txWord;
        SEL_RX_DATA, SEL_RX_PEEK: portRd[p] = rxWord;
        SEL_TX_CTRL:              portRd[p] = txCtrlWord;
        SEL_RX_CTRL:              portRd[p] = rxCtrlWord;
        default:                  portRd[p] = '0;
      endcase
    end
  end

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FLAG_W = 7,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              devWrEn,
  input  logic              devRdEn,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [DATA_W-1:0] devWrData,
  output logic [DATA_W-1:0] devRdData,
  output logic              txEvent,
  output logic              rxEvent
);

  mbx_strobe_t       strobe;
  mbx_sel_t          portSel [NUM_PORTS];
  logic [DATA_W-1:0] portRd  [NUM_PORTS];
  logic              txFull;
  logic              rxFull;

  mbx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWrEn (hostWrEn),
    .hostRdEn (hostRdEn),
    .hostAddr (hostAddr),
    .devWrEn  (devWrEn),
    .devRdEn  (devRdEn),
    .devAddr  (devAddr),
    .txFull   (txFull),
    .strobe   (strobe),
    .hostSel  (portSel[PORT_HOST]),
    .devSel   (portSel[PORT_DEV]),
    .txEvent  (txEvent),
    .rxEvent  (rxEvent)
  );

  mbx_datapath #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostWrData (hostWrData),
    .devWrData  (devWrData),
    .portSel    (portSel),
    .portRd     (portRd),
    .txFull     (txFull),
    .rxFull     (rxFull)
  );

  assign hostRdData = portRd[PORT_HOST];
  assign devRdData  = portRd[PORT_DEV];

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic              hostRdEn,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [DATA_W-1:0] hostRdData,
  input logic              devWrEn,
  input logic              devRdEn,
  input logic [ADDR_W-1:0] devAddr,
  input logic [DATA_W-1:0] devRdData,
  input logic              txFull,
  input logic              rxFull,
  input logic              txEvent,
  input logic              rxEvent
);

  logic hTxWr, dTxRd, dRxWr, rxRd;
  always_comb begin
    hTxWr = hostWrEn && (hostAddr == ADDR_W'(OFF_TX_DATA));
    dTxRd = devRdEn  && (devAddr  == ADDR_W'(OFF_TX_DATA));
    dRxWr = devWrEn  && (devAddr  == ADDR_W'(OFF_RX_DATA));
    rxRd  = (hostRdEn && (hostAddr == ADDR_W'(OFF_RX_DATA)))
         || (devRdEn  && (devAddr  == ADDR_W'(OFF_RX_DATA)));
  end

  AST_TX_FILL: assert property (@(posedge clk) disable iff (!rstN) hTxWr |=> txFull); // R2
  AST_TX_TAKE: assert property (@(posedge clk) disable iff (!rstN) (dTxRd && !hTxWr) |=> !txFull); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN) (!dTxRd && !hTxWr) |=> $stable(txFull)); // R7
  AST_TX_COLLIDE: assert property (@(posedge clk) disable iff (!rstN) (dTxRd && hTxWr) |=> txFull); // R4
  AST_RX_FILL: assert property (@(posedge clk) disable iff (!rstN) dRxWr |=> rxFull); // R5
  AST_RX_TAKE: assert property (@(posedge clk) disable iff (!rstN) (rxRd && !dRxWr) |=> !rxFull); // R5
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN) (!rxRd && !dRxWr) |=> $stable(rxFull)); // R7
  AST_TX_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rstN) txEvent |-> $past(dTxRd && txFull && !hTxWr)); // R9
  AST_TX_EVENT_FIRE: assert property (@(posedge clk) disable iff (!rstN) (dTxRd && txFull && !hTxWr) |=> txEvent); // R9
  AST_RX_EVENT_FIRE: assert property (@(posedge clk) disable iff (!rstN) dRxWr |=> rxEvent); // R10
  AST_RX_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rstN) rxEvent |-> $past(dRxWr)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN) (!hostRdEn |-> hostRdData == '0) and (!devRdEn |-> devRdData == '0)); // R11

endmodule

bind dbg_mailbox mbx_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mbxChecker (
  .clk        (clk),
  .rstN       (rstN),
  .hostWrEn   (hostWrEn),
  .hostRdEn   (hostRdEn),
  .hostAddr   (hostAddr),
  .hostRdData (hostRdData),
  .devWrEn    (devWrEn),
  .devRdEn    (devRdEn),
  .devAddr    (devAddr),
  .devRdData  (devRdData),
  .txFull     (txFull),
  .rxFull     (rxFull),
  .txEvent    (txEvent),
  .rxEvent    (rxEvent)
);

// File: tb/dbg_mailbox_bench.sv
module dbg_mailbox_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0, devWrEn = 1'b0, devRdEn = 1'b0;
  logic [11:0] hostAddr = '0, devAddr = '0;
  logic [31:0] hostWrData = '0, devWrData = '0;
  logic [31:0] hostRdData, devRdData;
  logic        txEvent, rxEvent;

  always #5 clk = ~clk;

  dbg_mailbox u_dbg_mailbox (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .devWrEn(devWrEn), .devRdEn(devRdEn), .devAddr(devAddr),
    .devWrData(devWrData), .devRdData(devRdData),
    .txEvent(txEvent), .rxEvent(rxEvent)
  );

  typedef struct {
    logic        chkHost;
    logic [31:0] expHost;
    logic        chkDev;
    logic [31:0] expDev;
    logic        expTxEv;
    logic        expRxEv;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, derived from the requirements
  logic [31:0] mTxWord = '0, mRxWord = '0;
  logic [6:0]  mTxFlags = '0, mRxFlags = '0;
  logic        mTxFull = 0, mRxFull = 0, mTxEv = 0, mRxEv = 0;

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    case (a)
      12'h100, 12'h110: return mTxWord;
      12'h108, 12'h114: return mRxWord;
      12'h104:          return {24'h0, mTxFlags, mTxFull};
      12'h10C:          return {24'h0, mRxFlags, mRxFull};
      default:          return 32'h0;
    endcase
  endfunction

  task automatic op(input logic hw, input logic hr, input logic [11:0] ha, input logic [31:0] hd,
                    input logic dw, input logic dr, input logic [11:0] da, input logic [31:0] dd,
                    input string tag);
    item_t it;
    logic hTx, dTx, dRx, rTake;
    @(negedge clk); #1;
    hostWrEn = hw; hostRdEn = hr; hostAddr = ha; hostWrData = hd;
    devWrEn = dw;  devRdEn = dr;  devAddr = da;  devWrData = dd;
    it.chkHost = hr; it.expHost = hr ? modelRead(ha) : 32'h0;
    it.chkDev  = dr; it.expDev  = dr ? modelRead(da) : 32'h0;
    it.expTxEv = mTxEv; it.expRxEv = mRxEv; it.tag = tag;
    q.push_back(it);
    hTx = hw && ha == 12'h100;
    dTx = dr && da == 12'h100;
    dRx = dw && da == 12'h108;
    rTake = (hr && ha == 12'h108) || (dr && da == 12'h108);
    mTxEv = dTx && mTxFull && !hTx;
    mRxEv = dRx;
    if (hTx) begin mTxWord = hd; mTxFull = 1; end else if (dTx) mTxFull = 0;
    if (dRx) begin mRxWord = dd; mRxFull = 1; end else if (rTake) mRxFull = 0;
    if (hw && ha == 12'h104) mTxFlags = hd[7:1];
    if (dw && da == 12'h10C) mRxFlags = dd[7:1];
  endtask

  task automatic idle(input string tag);
    op(0, 0, 12'h0, 32'h0, 0, 0, 12'h0, 32'h0, tag);
  endtask

  task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the expectation for the current cycle just before the edge
  initial begin
    forever begin
      @(negedge clk); #4;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.chkHost) compare(hostRdData, it.expHost, "hostRdData", it.tag);
        if (it.chkDev)  compare(devRdData, it.expDev, "devRdData", it.tag);
        compare({31'h0, txEvent}, {31'h0, it.expTxEv}, "R9 txEvent", it.tag);
        compare({31'h0, rxEvent}, {31'h0, it.expRxEv}, "R10 rxEvent", it.tag);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    op(0, 1, 12'h104, 0, 0, 1, 12'h10C, 0, "R1 ctrl");
    op(0, 1, 12'h100, 0, 0, 1, 12'h114, 0, "R1 data");
    // R2 fill, R7 peek, R3 host read non-destructive
    op(1, 0, 12'h100, 32'hA5A5_0001, 0, 0, 12'h0, 0, "R2 fill");
    op(0, 1, 12'h104, 0, 0, 1, 12'h110, 0, "R7 tx peek");
    op(0, 1, 12'h100, 0, 0, 1, 12'h110, 0, "R3 host read");
    op(0, 1, 12'h104, 0, 0, 0, 12'h0, 0, "R3 status kept");
    // R2 overwrite while full, R3 device drain, R9 event
    op(1, 0, 12'h100, 32'h0000_BEEF, 0, 0, 12'h0, 0, "R2 overwrite");
    op(0, 1, 12'h104, 0, 0, 1, 12'h100, 0, "R3 drain");
    op(0, 1, 12'h104, 0, 0, 0, 12'h0, 0, "R9 after drain");
    // R3 read while empty: no status change, no event
    op(0, 0, 12'h0, 0, 0, 1, 12'h100, 0, "R3 empty read");
    op(0, 1, 12'h104, 0, 0, 0, 12'h0, 0, "R3 still empty");
    // R4 outbound collision
    op(1, 0, 12'h100, 32'h0000_1111, 0, 0, 12'h0, 0, "R4 prefill");
    op(1, 0, 12'h100, 32'h0000_2222, 0, 1, 12'h100, 0, "R4 collide");
    op(0, 1, 12'h104, 0, 0, 1, 12'h110, 0, "R4 after");
    op(0, 0, 12'h0, 0, 0, 1, 12'h100, 0, "R4 drain new");
    idle("R9 event");
    // R5 inbound fill, R10 event, host read clears
    op(0, 0, 12'h0, 0, 1, 0, 12'h108, 32'h0000_CAFE, "R5 fill");
    op(0, 1, 12'h10C, 0, 0, 0, 12'h0, 0, "R5 status");
    op(0, 1, 12'h108, 0, 0, 0, 12'h0, 0, "R5 host read");
    op(0, 1, 12'h10C, 0, 0, 0, 12'h0, 0, "R5 cleared");
    // R5 device flush
    op(0, 0, 12'h0, 0, 1, 0, 12'h108, 32'h0000_3333, "R5 refill");
    op(0, 0, 12'h0, 0, 0, 1, 12'h108, 0, "R5 flush");
    op(0, 1, 12'h10C, 0, 0, 0, 12'h0, 0, "R5 flushed");
    // R6 inbound collision, R7 peek
    op(0, 0, 12'h0, 0, 1, 0, 12'h108, 32'h0000_4444, "R6 prefill");
    op(0, 1, 12'h108, 0, 1, 0, 12'h108, 32'h0000_5555, "R6 collide");
    op(0, 1, 12'h114, 0, 0, 1, 12'h114, 0, "R7 rx peek");
    op(0, 1, 12'h10C, 0, 0, 1, 12'h10C, 0, "R6 status");
    // R8 flags and cross-side writes ignored
    op(1, 0, 12'h104, 32'h0000_00AA, 0, 0, 12'h0, 0, "R8 host flags");
    op(0, 0, 12'h0, 0, 1, 0, 12'h104, 32'h0000_00FE, "R8 dev to tx ctrl");
    op(0, 1, 12'h104, 0, 0, 1, 12'h104, 0, "R8 tx ctrl");
    op(0, 0, 12'h0, 0, 1, 0, 12'h10C, 32'hFFFF_0034, "R8 dev flags");
    op(1, 0, 12'h10C, 32'h0000_00FE, 0, 0, 12'h0, 0, "R8 host to rx ctrl");
    op(1, 0, 12'h108, 32'hDEAD_0000, 1, 0, 12'h100, 32'hDEAD_0001, "R8 cross data");
    op(0, 1, 12'h10C, 0, 0, 1, 12'h110, 0, "R8 rx ctrl");
    op(0, 1, 12'h114, 0, 0, 1, 12'h104, 0, "R8 words kept");
    // R11 unmapped
    op(0, 1, 12'h118, 0, 0, 1, 12'h0FC, 0, "R11 unmapped");
    idle("R11 idle");
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule